// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged Receive Queue

This block recovers asynchronous serial characters from a single input line. It is clocked by the system clock and advances its bit timing only on a one-cycle enable that pulses sixteen times per bit period. A falling edge on the idle-high line opens a candidate start bit. The candidate is confirmed near the middle of that bit, and every later bit is then sampled sixteen enables apart, so each sample lands in the centre of its bit cell. The character length (5 to 8 bits), the parity mode and the receive-ready threshold come from static configuration inputs.

Each finished character goes into a 16-entry first-in first-out queue together with its own parity, framing and break flags. The status byte shows the flags of the character at the head of the queue, an overrun flag, a data-available bit and a summary bit that is set while any stored character carries an error. A consumer pops characters with a one-cycle read strobe. It acknowledges the status with a separate strobe, which clears the error bits. A ready output rises once the queue holds at least the selected number of characters.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, every bit of `lsr` reads 0 and `rx_ready` is 0. Bits 5 and 6 of `lsr` always read 0.
- R2: A start bit is accepted only if the synchronised line is still low on the 8th enable after the falling edge was seen. A shorter low pulse is dropped without storing a character.
- R3: Data bits are taken least significant bit first. `word_len` 00, 01, 10 and 11 select 5, 6, 7 and 8 bits, and unused upper bits of `rx_data` read 0.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_stick` 0 it must make the count of ones even (`par_even` 1) or odd (`par_even` 0). With `par_stick` 1 it must equal the inverse of `par_even`. A mismatch tags the character with a parity error, shown in `lsr` bit 2.
- R5: A stop bit sampled low tags the character with a framing error, shown in `lsr` bit 3.
- R6: If every sampled bit of a frame is low, including the stop position, one entry is stored with data 0 and only the break flag, shown in `lsr` bit 4. No new start bit is looked for until the line is high again.
- R7: The queue holds 16 characters and returns them in arrival order. A one-cycle `rd_data` strobe removes the head. `lsr` bit 0 is 1 exactly while the queue is non-empty.
- R8: A character that completes while the queue is full, and no pop happens in the same cycle, is discarded and sets `lsr` bit 1.
- R9: `lsr` bits 2 to 4 take the flags of a character when it becomes the head of the queue and hold them. A `rd_lsr` strobe clears `lsr` bits 1 to 4 from the next cycle on. A flag that is set in the same cycle wins over the clear.
- R10: `lsr` bit 7 is 1 while at least one stored character carries any error flag, whatever its position in the queue.
- R11: `rx_ready` is 1 while the fill level is at least the level selected by `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| word_len | input | 2 | Character length select, 5 to 8 bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select, or stick value select |
| par_stick | input | 1 | Stick parity mode |
| trig_sel | input | 2 | Receive-ready fill threshold select |
| rd_data | input | 1 | Pop the head character |
| rd_lsr | input | 1 | Status acknowledge, clears error bits |
| rx_data | output | 8 | Data of the head character |
| lsr | output | 8 | Line status byte |
| rx_ready | output | 1 | Fill level at or above threshold |

## Verification
The hardest case to reach from the ports is a character that arrives while all sixteen entries are occupied. The stimulus streams sixteen frames back to back without a single pop, then sends a seventeenth. It checks that the overrun bit rises, that the acknowledge strobe clears it, and that draining returns exactly the first sixteen values. The error summary bit is just as hard to observe alone: a clean character is placed ahead of a parity-failing one, so bit 7 is set while the head flags are still clear.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    // index of the last data bit for a length select (5..8 bits)
    function automatic logic [2:0] last_bit_idx(input logic [1:0] sel);
        return {1'b1, sel};
    endfunction

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic expected_parity(input logic [DATA_W-1:0] d,
                                             input logic even,
                                             input logic stick);
        if (stick) return ~even;
        return even ? ^d : ~^d;
    endfunction

    function automatic logic entry_has_err(input rx_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxs,
    input  logic [1:0] word_len,
    input  logic      par_en,
    input  logic      par_even,
    input  logic      par_stick,
    output logic      push,
    output rx_entry_t entry
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [2:0]        bidx;
    logic [DATA_W-1:0] dbuf;
    logic              all_low;
    logic              par_bad;
    logic              is_brk;

    assign is_brk = all_low & ~rxs;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            dbuf    <= '0;
            all_low <= 1'b1;
            par_bad <= 1'b0;
            push    <= 1'b0;
            entry   <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxs) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rxs) begin
                                state   <= RX_DATA;
                                bidx    <= '0;
                                dbuf    <= '0;
                                all_low <= 1'b1;
                                par_bad <= 1'b0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST) begin
                            cnt        <= '0;
                            dbuf[bidx] <= rxs;
                            all_low    <= all_low & ~rxs;
                            if (bidx == last_bit_idx(word_len))
                                state <= par_en ? RX_PAR : RX_STOP;
                            else
                                bidx <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            par_bad <= (rxs != expected_parity(dbuf, par_even, par_stick));
                            all_low <= all_low & ~rxs;
                            state   <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            push <= 1'b1;
                            if (is_brk) begin
                                entry <= '{brk: 1'b1, frm: 1'b0, par: 1'b0, data: '0};
                                state <= RX_BRKWAIT;
                            end else begin
                                entry <= '{brk: 1'b0, frm: ~rxs, par: par_bad, data: dbuf};
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_BRKWAIT: begin
                        if (rxs) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 11,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CNT_W'(wr) - CNT_W'(rd);
        end
    end

    assign dout = mem[rp];
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic [1:0] trig_sel,
    input  logic       rd_data,
    input  logic       rd_lsr,
    output logic [7:0] rx_data,
    output logic [7:0] lsr,
    output logic       rx_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             rxs;
    logic             frm_push;
    rx_entry_t        frm_entry;
    logic [ENTRY_W-1:0] fifo_dout;
    rx_entry_t        head;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_full, fifo_empty;
    logic             push_ok, popping, head_new, head_new_q;
    logic             ovr;
    logic [2:0]       sticky;   // {brk, frm, par}
    logic [CNT_W-1:0] err_cnt;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .din (rx_in), .dout (rxs)
    );

    rx_frame #(.OSR(OSR)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .rxs       (rxs),
        .word_len  (word_len),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .push      (frm_push),
        .entry     (frm_entry)
    );

    assign fifo_full  = (fifo_cnt == CNT_W'(DEPTH));
    assign fifo_empty = (fifo_cnt == '0);
    assign popping    = rd_data && !fifo_empty;
    assign push_ok    = frm_push && (!fifo_full || popping);

    rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .wr    (push_ok),
        .rd    (popping),
        .din   (frm_entry),
        .dout  (fifo_dout),
        .count (fifo_cnt)
    );

    assign head = rx_entry_t'(fifo_dout);

    // a different character sits at the head after this edge
    assign head_new = (push_ok && (fifo_empty || (popping && fifo_cnt == CNT_W'(1))))
                   || (popping && fifo_cnt > CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            head_new_q <= 1'b0;
            sticky     <= '0;
            ovr        <= 1'b0;
            err_cnt    <= '0;
        end else begin
            head_new_q <= head_new;
            if (head_new_q)
                sticky <= (rd_lsr ? 3'b000 : sticky) | {head.brk, head.frm, head.par};
            else if (rd_lsr)
                sticky <= '0;
            if (frm_push && fifo_full && !popping) ovr <= 1'b1;
            else if (rd_lsr)                       ovr <= 1'b0;
            err_cnt <= err_cnt + CNT_W'(push_ok && entry_has_err(frm_entry))
                               - CNT_W'(popping && entry_has_err(head));
        end
    end

    assign rx_data  = head.data;
    assign lsr      = {(err_cnt != '0), 2'b00, sticky, ovr, !fifo_empty};
    assign rx_ready = (fifo_cnt >= CNT_W'(trig_level(trig_sel)));
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             frm_push,
    input logic             fifo_full,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             rd_data,
    input logic             rd_lsr,
    input logic [7:0]       lsr,
    input logic             rx_ready
);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(DEPTH));

    assert_pop_shrinks_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_data && lsr[0] && !frm_push) |=> (fifo_cnt == $past(fifo_cnt) - 1'b1));

    assert_ready_has_data_R11: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> lsr[0]);

    assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (frm_push && fifo_full && !rd_data) |=> lsr[1]);

    assert_ack_clears_overrun_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !frm_push) |=> !lsr[1]);

    assert_summary_needs_data_R10: assert property (@(posedge clk) disable iff (rst)
        lsr[7] |-> lsr[0]);

    assert_reserved_low_R1: assert property (@(posedge clk) disable iff (rst)
        lsr[6:5] == 2'b00);
endmodule

bind serial_rx_core serial_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_push  (frm_push),
    .fifo_full (fifo_full),
    .fifo_cnt  (fifo_cnt),
    .rd_data   (rd_data),
    .rd_lsr    (rd_lsr),
    .lsr       (lsr),
    .rx_ready  (rx_ready)
);

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       rd_data = 1'b0, rd_lsr = 1'b0;
    logic [7:0] rx_data, lsr;
    logic       rx_ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // expected entries: {brk, frm, par, data}
    logic [10:0] exp_q[$];

    localparam int BIT_CLKS = 64;   // 16 enables, one every 4 clocks

    serial_rx_core u0 (
        .clk (clk), .rst (rst), .tick16 (tick16), .rx_in (rx_in),
        .word_len (word_len), .par_en (par_en), .par_even (par_even),
        .par_stick (par_stick), .trig_sel (trig_sel),
        .rd_data (rd_data), .rd_lsr (rd_lsr),
        .rx_data (rx_data), .lsr (lsr), .rx_ready (rx_ready)
    );

    always #5 clk = ~clk;

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick16 = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic hold_line(input logic v, input int clks);
        rx_in = v;
        repeat (clks) @(negedge clk);
    endtask

    function automatic logic ones_odd(input logic [7:0] d, input int nb);
        logic r = 1'b0;
        for (int i = 0; i < nb; i++) r ^= d[i];
        return r;
    endfunction

    // send one frame; pbit used only when par_en
    task automatic send_raw(input logic [7:0] d, input logic pbit, input logic stopv);
        int nb = 5 + int'(word_len);
        hold_line(1'b0, BIT_CLKS);
        for (int i = 0; i < nb; i++) hold_line(d[i], BIT_CLKS);
        if (par_en) hold_line(pbit, BIT_CLKS);
        hold_line(stopv, BIT_CLKS);
        hold_line(1'b1, 16);
    endtask

    // driver: correct or deliberately wrong parity, stop as given
    task automatic drive_char(input logic [7:0] d, input bit bad_par, input logic stopv,
                              input bit expect_it);
        int nb = 5 + int'(word_len);
        logic [7:0] m = d & ((8'd1 << nb) - 8'd1);
        logic good;
        if (par_stick) good = ~par_even;
        else           good = par_even ? ones_odd(m, nb) : ~ones_odd(m, nb);
        if (expect_it)
            exp_q.push_back({1'b0, ~stopv, (par_en && bad_par), m});
        send_raw(m, bad_par ? ~good : good, stopv);
    endtask

    // monitor: compare head with queue front, acknowledge, pop
    task automatic take_char(input string req);
        logic [10:0] e;
        if (exp_q.size() == 0) begin
            chk(1'b0, {req, " queue empty"}, 0, 1);
            return;
        end
        e = exp_q.pop_front();
        chk(lsr[0] == 1'b1, {req, " R7 data ready"}, lsr[0], 1);
        chk(rx_data == e[7:0], {req, " data"}, rx_data, e[7:0]);
        chk(lsr[4:2] == e[10:8], {req, " flags"}, lsr[4:2], e[10:8]);
        @(negedge clk); rd_lsr = 1'b1;
        @(negedge clk); rd_lsr = 1'b0;
        chk(lsr[4:1] == 4'h0, {req, " R9 cleared"}, lsr[4:1], 0);
        rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);

        // R1 reset state
        chk(lsr == 8'h00, "R1 lsr after reset", lsr, 0);
        chk(rx_ready == 1'b0, "R1 ready after reset", rx_ready, 0);

        // R3 8 data bits, no parity; R11 level 1
        drive_char(8'hA5, 0, 1'b1, 1);
        chk(rx_ready == 1'b1, "R11 level 1", rx_ready, 1);
        take_char("R3 8N1");
        chk(lsr[0] == 1'b0, "R7 empty after pop", lsr[0], 0);

        // R2 short low pulse is a glitch
        hold_line(1'b0, 12);
        hold_line(1'b1, 800);
        chk(lsr[0] == 1'b0, "R2 glitch dropped", lsr[0], 0);

        // R4 even parity, 7 bits; R10 summary with clean head
        word_len = 2'd2; par_en = 1'b1; par_even = 1'b1;
        drive_char(8'h35, 0, 1'b1, 1);
        drive_char(8'h35, 1, 1'b1, 1);
        chk(lsr[7] == 1'b1, "R10 error deeper in queue", lsr[7], 1);
        chk(lsr[4:2] == 3'b000, "R9 head flags clean", lsr[4:2], 0);
        take_char("R4 even good");
        take_char("R4 even bad");
        chk(lsr[7] == 1'b0, "R10 summary clears", lsr[7], 0);

        // R4 odd parity
        par_even = 1'b0;
        drive_char(8'h35, 0, 1'b1, 1);
        take_char("R4 odd good");

        // R4 stick parity
        par_stick = 1'b1;
        drive_char(8'h12, 0, 1'b1, 1);
        drive_char(8'h12, 1, 1'b1, 1);
        take_char("R4 stick one");
        take_char("R4 stick one wrong");
        par_even = 1'b1;
        drive_char(8'h6C, 0, 1'b1, 1);
        take_char("R4 stick zero");
        par_stick = 1'b0; par_even = 1'b0; par_en = 1'b0;

        // R3 5-bit characters
        word_len = 2'd0;
        drive_char(8'h13, 0, 1'b1, 1);
        drive_char(8'hFF, 0, 1'b1, 1);
        take_char("R3 5-bit a");
        take_char("R3 5-bit b");

        // R5 framing error
        word_len = 2'd3;
        drive_char(8'h5A, 0, 1'b0, 1);
        take_char("R5 framing");

        // R6 break: line low for twelve bit times
        hold_line(1'b0, 12 * BIT_CLKS);
        hold_line(1'b1, 2 * BIT_CLKS);
        exp_q.push_back({3'b100, 8'h00});
        take_char("R6 break");
        chk(lsr[0] == 1'b0, "R6 single break entry", lsr[0], 0);

        // R11 threshold 4 and 8
        trig_sel = 2'd1;
        for (int i = 0; i < 3; i++) drive_char(8'h40 + 8'(i), 0, 1'b1, 1);
        chk(rx_ready == 1'b0, "R11 below 4", rx_ready, 0);
        drive_char(8'h43, 0, 1'b1, 1);
        chk(rx_ready == 1'b1, "R11 at 4", rx_ready, 1);
        trig_sel = 2'd2;
        #1;
        chk(rx_ready == 1'b0, "R11 below 8", rx_ready, 0);
        for (int i = 0; i < 4; i++) take_char("R7 order");
        trig_sel = 2'd0;

        // R8 overrun: fill 16 then one more
        for (int i = 0; i < 16; i++) drive_char(8'h80 + 8'(i), 0, 1'b1, 1);
        chk(lsr[1] == 1'b0, "R8 no overrun when exactly full", lsr[1], 0);
        drive_char(8'hEE, 0, 1'b1, 0);
        chk(lsr[1] == 1'b1, "R8 overrun set", lsr[1], 1);
        @(negedge clk); rd_lsr = 1'b1;
        @(negedge clk); rd_lsr = 1'b0;
        chk(lsr[1] == 1'b0, "R9 overrun cleared", lsr[1], 0);
        for (int i = 0; i < 16; i++) take_char("R8 drain");
        chk(lsr[0] == 1'b0, "R8 dropped char absent", lsr[0], 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule